// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned WIDTH-bit operands and returns a 2*WIDTH-bit product. It uses one adder over many clock cycles instead of a full array multiplier. A three-state Moore controller drives a separate datapath through five named controls: load multiplicand, load multiplier, load accumulator, shift multiplier and clear accumulator. The datapath holds the multiplicand, the multiplier (which becomes the low half of the product) and an accumulator (which becomes the high half).

The controller has three states: IDLE, SETUP and ACTIVE. There are four transitions:
- IDLE to IDLE while start is low.
- IDLE to SETUP when start is sampled high.
- SETUP to ACTIVE unconditionally. This transition clears the iteration counter.
- ACTIVE to ACTIVE while the counter is below WIDTH-1, and ACTIVE to IDLE when the counter reaches WIDTH-1.

In SETUP the operands present on the inputs are captured and the accumulator is cleared. Each ACTIVE cycle adds the multiplicand to the accumulator when the multiplier's least significant bit is 1. The accumulator and the multiplier then shift right together, and the carry-out of the adder enters the top bit. The `done` output is high exactly while the controller is in IDLE.

To use the block, raise `start` for one cycle while `done` is high. Hold the operands valid through the following cycle, which is the SETUP cycle. Then wait for `done` to return high and read `product`.

Top module: `shmul_top`

## Requirements
- R1: After a synchronous reset, `done` is 1 and `product` is 0.
- R2: When `start` is sampled high while `done` is 1, `done` is 0 in the next cycle.
- R3: The operands are taken from `opnd_a`/`opnd_b` during the cycle after `start` is sampled (SETUP). Later changes to the operands do not affect the result.
- R4: Once an operation begins, `done` stays 0 for exactly WIDTH+1 cycles: one SETUP cycle and WIDTH ACTIVE cycles.
- R5: When `done` returns to 1, `product` equals the unsigned product of the captured operands. This includes zero, one and all-ones operands, and the product does not depend on any earlier result.
- R6: While `done` is 1 and `start` is 0, `product` stays unchanged whatever the operand inputs do.
- R7: A `start` that is high while `done` is 0 has no effect. Neither the length of the operation nor its result changes.
- R8: A synchronous reset during an operation makes `done` 1 and `product` 0 in the next cycle.
- R9: `done` depends on the controller state alone. Raising `start` does not change `done` before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin an operation when sampled high in IDLE |
| opnd_a | input | WIDTH | Multiplicand |
| opnd_b | input | WIDTH | Multiplier |
| product | output | 2*WIDTH | Accumulator (high half) concatenated with shifted multiplier (low half) |
| done | output | 1 | High while the unit is idle |

## Verification
A controller that miscounts iterations, skips SETUP or leaves ACTIVE too early shows up as `done` rising one or more cycles away from WIDTH+1 cycles after its fall. This is visible on the very operation where the fault occurs. A fault in the add-shift path, the carry insertion or the accumulator clear shows up as a wrong `product` at the first rising edge of `done`. The all-ones case exercises the carry path, and running operations back to back exposes a missing clear. A datapath that keeps shifting or loading outside ACTIVE shows up as a `product` that drifts while `done` is high.

// File: rtl/shmul_pkg.sv
package shmul_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_ACTIVE = 2'd2
    } shmul_state_e;

    // Control word driven by the controller into the datapath.
    typedef struct packed {
        logic done;
        logic ld_mcand;
        logic ld_mplier;
        logic ld_acc;
        logic shift_mplier;
        logic clr_acc;
    } shmul_ctl_t;

endpackage

// File: rtl/shmul_ctrl.sv
module shmul_ctrl
    import shmul_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output shmul_ctl_t ctl
);
    localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST_ITER = CNT_W'(WIDTH - 1);

    shmul_state_e     state_q, state_d;
    logic [CNT_W-1:0] iter_q, iter_d;

    // Next-state and counter function.
    always_comb begin
        state_d = state_q;
        iter_d  = iter_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_SETUP;
            end
            ST_SETUP: begin
                iter_d  = '0;
                state_d = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (iter_q == LAST_ITER) begin
                    iter_d  = '0;
                    state_d = ST_IDLE;
                end else begin
                    iter_d = iter_q + 1'b1;
                end
            end
            default: begin
                iter_d  = '0;
                state_d = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            iter_q  <= '0;
        end else begin
            state_q <= state_d;
            iter_q  <= iter_d;
        end
    end

    // Moore output: control word from state alone.
    always_comb begin
        unique case (state_q)
            ST_IDLE:   ctl = '{done: 1'b1, ld_mcand: 1'b0, ld_mplier: 1'b0,
                               ld_acc: 1'b0, shift_mplier: 1'b0, clr_acc: 1'b0};
            ST_SETUP:  ctl = '{done: 1'b0, ld_mcand: 1'b1, ld_mplier: 1'b1,
                               ld_acc: 1'b0, shift_mplier: 1'b0, clr_acc: 1'b1};
            ST_ACTIVE: ctl = '{done: 1'b0, ld_mcand: 1'b0, ld_mplier: 1'b0,
                               ld_acc: 1'b1, shift_mplier: 1'b1, clr_acc: 1'b0};
            default:   ctl = '{done: 1'b1, ld_mcand: 1'b0, ld_mplier: 1'b0,
                               ld_acc: 1'b0, shift_mplier: 1'b0, clr_acc: 1'b0};
        endcase
    end

endmodule

// File: rtl/shmul_dpath.sv
module shmul_dpath #(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [WIDTH-1:0]   opnd_a,
    input  logic [WIDTH-1:0]   opnd_b,
    input  logic               ld_mcand,
    input  logic               ld_mplier,
    input  logic               ld_acc,
    input  logic               shift_mplier,
    input  logic               clr_acc,
    output logic [2*WIDTH-1:0] product
);
    localparam int SUM_W = WIDTH + 1;

    logic [WIDTH-1:0] mcand_q;
    logic [WIDTH-1:0] mplier_q;
    logic [WIDTH-1:0] acc_q;
    logic [SUM_W-1:0] sum;

    // Conditional add: multiplicand gated by the multiplier LSB.
    always_comb begin
        sum = {1'b0, acc_q} + (mplier_q[0] ? {1'b0, mcand_q} : '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand_q <= '0;
        end else if (ld_mcand) begin
            mcand_q <= opnd_a;
        end
    end

    // Accumulator takes the sum shifted right, carry entering its top bit.
    always_ff @(posedge clk) begin
        if (rst || clr_acc) begin
            acc_q <= '0;
        end else if (ld_acc) begin
            acc_q <= sum[SUM_W-1:1];
        end
    end

    // Multiplier shifts right, receiving the bit dropped by the accumulator.
    always_ff @(posedge clk) begin
        if (rst) begin
            mplier_q <= '0;
        end else if (ld_mplier) begin
            mplier_q <= opnd_b;
        end else if (shift_mplier) begin
            mplier_q <= {sum[0], mplier_q[WIDTH-1:1]};
        end
    end

    assign product = {acc_q, mplier_q};

endmodule

// File: rtl/shmul_top.sv
module shmul_top
    import shmul_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [WIDTH-1:0]   opnd_a,
    input  logic [WIDTH-1:0]   opnd_b,
    output logic [2*WIDTH-1:0] product,
    output logic               done
);
    shmul_ctl_t ctl;

    shmul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl)
    );

    shmul_dpath #(.WIDTH(WIDTH)) u_dpath (
        .clk          (clk),
        .rst          (rst),
        .opnd_a       (opnd_a),
        .opnd_b       (opnd_b),
        .ld_mcand     (ctl.ld_mcand),
        .ld_mplier    (ctl.ld_mplier),
        .ld_acc       (ctl.ld_acc),
        .shift_mplier (ctl.shift_mplier),
        .clr_acc      (ctl.clr_acc),
        .product      (product)
    );

    assign done = ctl.done;

endmodule

// File: rtl/shmul_checker.sv
module shmul_checker #(
    parameter int WIDTH = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [WIDTH-1:0]   opnd_a,
    input logic [WIDTH-1:0]   opnd_b,
    input logic [2*WIDTH-1:0] product,
    input logic               done
);
    localparam int LC_W = $clog2(WIDTH + 2) + 1;

    logic [LC_W-1:0]    low_cnt;
    logic               prev_done;
    logic [2*WIDTH-1:0] cap_a, cap_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt   <= '0;
            prev_done <= 1'b1;
            cap_a     <= '0;
            cap_b     <= '0;
        end else begin
            prev_done <= done;
            low_cnt   <= done ? '0 : low_cnt + 1'b1;
            if (!done && prev_done) begin
                cap_a <= {{WIDTH{1'b0}}, opnd_a};
                cap_b <= {{WIDTH{1'b0}}, opnd_b};
            end
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (done && product == '0)); // R1

    AST_START_DROPS_DONE: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !done); // R2

    AST_SETUP_THEN_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        (!done && prev_done) |=> !done); // R4

    AST_LOW_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (done && low_cnt != '0) |-> (low_cnt == LC_W'(WIDTH + 1))); // R4

    AST_PRODUCT_OK: assert property (@(posedge clk) disable iff (rst)
        (done && low_cnt != '0) |-> (product == cap_a * cap_b)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> $stable(product)); // R6

endmodule

bind shmul_top shmul_checker #(.WIDTH(WIDTH)) u_shmul_checker (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .product (product),
    .done    (done)
);

// File: tb/shmul_top_bench.sv
module shmul_top_bench;
    localparam int W = 16;
    localparam time HALF = 2.5ns;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [W-1:0]   opnd_a = '0;
    logic [W-1:0]   opnd_b = '0;
    logic [2*W-1:0] product;
    logic           done;

    int n_checks = 0;
    int n_fail   = 0;

    always #(HALF) clk = ~clk;

    shmul_top #(.WIDTH(W)) u_shmul_top (
        .clk(clk), .rst(rst), .start(start),
        .opnd_a(opnd_a), .opnd_b(opnd_b),
        .product(product), .done(done)
    );

    task automatic check(input bit ok, input string req,
                         input longint actual, input longint expected);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    // R1: reset state
    task automatic t_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(done == 1'b1, "R1 done", done, 1);
        check(product == '0, "R1 product", product, 0);
        rst = 1'b0;
    endtask

    // One operation; start is optionally kept high across the busy window (R7).
    task automatic t_mult(input logic [W-1:0] a, input logic [W-1:0] b,
                          input bit noisy_start);
        logic [2*W-1:0] exp_p;
        int lows;
        exp_p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
        @(negedge clk);
        opnd_a = a; opnd_b = b; start = 1'b1;
        #1;
        check(done == 1'b1, "R9 done before edge", done, 1);
        @(negedge clk);
        check(done == 1'b0, "R2 done after start", done, 0);
        start = noisy_start;
        lows = 1;
        @(negedge clk);
        // R3: scramble operands after the SETUP cycle
        opnd_a = ~a; opnd_b = b ^ 16'h5A5A;
        while (!done && lows < 4 * W) begin
            lows++;
            if (lows == W) start = 1'b0;
            @(negedge clk);
        end
        start = 1'b0;
        check(lows == W + 1, "R4 busy length", lows, W + 1);
        check(product == exp_p, "R5/R3/R7 product", product, exp_p);
        // R6: idle hold with moving operands
        for (int i = 0; i < 3; i++) begin
            opnd_a = opnd_a + 16'd7; opnd_b = opnd_b ^ 16'hFFFF;
            @(negedge clk);
        end
        check(product == exp_p, "R6 idle hold", product, exp_p);
    endtask

    // R8: reset in mid-operation
    task automatic t_mid_reset();
        @(negedge clk);
        opnd_a = 16'h1234; opnd_b = 16'hFFFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check(done == 1'b1, "R8 done", done, 1);
        check(product == '0, "R8 product", product, 0);
    endtask

    initial begin
        #(HALF * 2 * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        summary();
    end

    initial begin
        t_reset();
        t_mult(16'd0, 16'd0, 1'b0);
        t_mult(16'd1, 16'hBEEF, 1'b0);
        t_mult(16'hFFFF, 16'hFFFF, 1'b0);
        t_mult(16'hFFFF, 16'd1, 1'b0);
        t_mult(16'd0, 16'hFFFF, 1'b0);
        t_mult(16'd300, 16'd211, 1'b1);
        for (int k = 0; k < 8; k++) begin
            t_mult(16'($urandom), 16'($urandom), k[0]);
        end
        t_mid_reset();
        t_mult(16'h8001, 16'h8001, 1'b0);
        summary();
    end

endmodule